// File: doc/BRIEF.md
# Program Memory Block Access Guard

This block sits between a processor's table-access port and its program memory. For each access it decides whether the access may proceed. The decision uses the address being accessed, the address of the instruction doing the access, whether the access is a read or a write, and a protection word. The memory below 64 KiB is split into protection blocks. A small boot block covers 0x000000–0x0007FF. Four user blocks follow, covering 0x000800–0x003FFF, 0x004000–0x007FFF, 0x008000–0x00BFFF and 0x00C000–0x00FFFF. Each block carries three protection bits: write-enable, read-open and programmer-open.

The guard gates writes and read data. A write to a write-locked block never reaches the memory. A read of a read-locked block returns data only when the program counter lies inside that same block. From anywhere else it returns zeros. Addresses at or above 0x010000 fall outside every block and are always allowed. The guard flags each dropped or zeroed access on a one-cycle pulse.

The protection word is one-way under software control. A configuration write can only clear bits. A full erase or a per-block erase from the programmer side is the only way to set them again. The word is not touched by the ordinary reset. The programmer-open bits do not affect table accesses. They only produce a grant for accesses arriving from the external programming port.

Top module: `pmem_guard`

## Requirements
- R1: Block index b is 0 for addresses 0x000000–0x0007FF. It is 1, 2, 3 and 4 for 0x000800–0x003FFF, 0x004000–0x007FFF, 0x008000–0x00BFFF and 0x00C000–0x00FFFF. Addresses at or above 0x010000 belong to no block.
- R2: The protection word `prot_o` holds write-enable bits at positions [4:0], read-open bits at [9:5] and programmer-open bits at [14:10], with bit b of each field for block b. A table write (req_valid_i=1, req_write_i=1) to block b raises `mem_we_o` only when write-enable bit b is 1.
- R3: A table read of block b whose read-open bit is 0 returns `mem_rdata_i` on `rdata_o` only if `pc_i` lies in block b. Otherwise it returns all zeros.
- R4: A table read of block b whose read-open bit is 1 returns `mem_rdata_i` whatever the value of `pc_i`.
- R5: Table accesses to addresses at or above 0x010000 are always allowed and never flagged.
- R6: A configuration write (cfg_wr_i=1) sets `prot_o` to `prot_o & cfg_wdata_i` on the next edge. Writing 1 to a bit that is 0 leaves it 0.
- R7: `erase_all_i` sets every protection bit to 1 on the next edge. `erase_blk_i[b]` sets bits b, 5+b and 10+b. An erase takes priority over a configuration write in the same cycle.
- R8: The protection word keeps its value while `rst_ni` is low and after it is released.
- R9: `ext_grant_o` is 1 when `ext_addr_i` lies in no block or when the programmer-open bit of its block is 1, and 0 otherwise. Programmer-open bits have no effect on table accesses.
- R10: `violation_o` is 0 in reset. On the edge after a cycle with a dropped write or a zeroed read it is 1 for one cycle. It is 0 after any cycle without such an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (flag only) |
| pc_i | input | ADDR_W | Address of the executing instruction |
| req_valid_i | input | 1 | Table access request |
| req_write_i | input | 1 | 1 = table write, 0 = table read |
| tbl_addr_i | input | ADDR_W | Table access target address |
| wdata_i | input | DATA_W | Table write data |
| mem_rdata_i | input | DATA_W | Read data from program memory |
| mem_addr_o | output | ADDR_W | Address to program memory |
| mem_wdata_o | output | DATA_W | Write data to program memory |
| mem_we_o | output | 1 | Gated write strobe to program memory |
| mem_re_o | output | 1 | Read strobe to program memory |
| rdata_o | output | DATA_W | Read data to processor, zeroed when denied |
| violation_o | output | 1 | One-cycle pulse after a denied access |
| ext_addr_i | input | ADDR_W | Address of an external programmer access |
| ext_grant_o | output | 1 | External access permitted |
| cfg_wr_i | input | 1 | Protection word write (clear-only) |
| cfg_wdata_i | input | 3*(NUM_USER_BLK+1) | Protection word write data |
| erase_all_i | input | 1 | Full erase: all protection bits to 1 |
| erase_blk_i | input | NUM_USER_BLK+1 | Per-block erase mask |
| prot_o | output | 3*(NUM_USER_BLK+1) | Current protection word |

## Verification
The access gating (`mem_we_o`, `rdata_o`, `ext_grant_o`) is combinational. The bench drives each request on a falling edge and checks these outputs one nanosecond later, before the next rising edge. `violation_o` is registered once. It is therefore checked just after the rising edge that follows the request, before the next request is driven. Changes to `prot_o` from configuration writes and erases show on the first rising edge after the strobe, and are checked there. For each protection pattern, the sweep tries every pair of boundary addresses as program counter and target, in both directions.

// File: rtl/pmem_guard_pkg.sv
`timescale 1ns/1ps
package pmem_guard_pkg;

  // field order inside the protection word
  typedef enum logic [1:0] {
    FLD_WR = 2'd0,
    FLD_RD = 2'd1,
    FLD_CP = 2'd2
  } prot_fld_e;

  function automatic int fld_base(prot_fld_e f, int nblk);
    return int'(f) * nblk;
  endfunction

  // lower bound of block b (block 0 is the boot block)
  function automatic longint blk_lo(int b, int boot_log2, int user_log2);
    if (b == 0) return 64'd0;
    if (b == 1) return 64'd1 << boot_log2;
    return longint'(b - 1) << user_log2;
  endfunction

  // exclusive upper bound of block b
  function automatic longint blk_hi(int b, int boot_log2, int user_log2);
    if (b == 0) return 64'd1 << boot_log2;
    return longint'(b) << user_log2;
  endfunction

endpackage

// File: rtl/pmem_blk_decode.sv
`timescale 1ns/1ps
module pmem_blk_decode
  import pmem_guard_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int BOOT_LOG2 = 11,
  parameter int USER_LOG2 = 14,
  parameter int NUM_BLK   = 5
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_BLK-1:0] hit_o
);

  logic [ADDR_W:0] addr_ext;
  assign addr_ext = {1'b0, addr_i};

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(blk_hi(b, BOOT_LOG2, USER_LOG2));
    if (b == 0) begin : g_boot
      assign hit_o[b] = addr_ext < HI;
    end else begin : g_user
      localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(blk_lo(b, BOOT_LOG2, USER_LOG2));
      assign hit_o[b] = (addr_ext >= LO) && (addr_ext < HI);
    end
  end

endmodule

// File: rtl/pmem_prot_reg.sv
`timescale 1ns/1ps
module pmem_prot_reg #(
  parameter int NUM_BLK = 5,
  parameter int CFG_W   = 3 * NUM_BLK
) (
  input  logic               clk_i,
  input  logic               cfg_wr_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  input  logic               erase_all_i,
  input  logic [NUM_BLK-1:0] erase_blk_i,
  output logic [CFG_W-1:0]   prot_o
);

  logic [CFG_W-1:0] set_mask;
  logic [CFG_W-1:0] prot_q;
  logic             erase_any;

  for (genvar f = 0; f < 3; f++) begin : g_fld
    assign set_mask[f*NUM_BLK +: NUM_BLK] = erase_blk_i | {NUM_BLK{erase_all_i}};
  end

  assign erase_any = erase_all_i | (|erase_blk_i);

  // deliberately outside the reset domain: survives ordinary resets
  always_ff @(posedge clk_i) begin
    if (erase_any)     prot_q <= prot_q | set_mask;
    else if (cfg_wr_i) prot_q <= prot_q & cfg_wdata_i;
  end

  assign prot_o = prot_q;

endmodule

// File: rtl/pmem_access_check.sv
`timescale 1ns/1ps
module pmem_access_check
  import pmem_guard_pkg::*;
#(
  parameter int NUM_BLK = 5,
  parameter int CFG_W   = 3 * NUM_BLK
) (
  input  logic [NUM_BLK-1:0] tgt_hit_i,
  input  logic [NUM_BLK-1:0] pc_hit_i,
  input  logic [NUM_BLK-1:0] ext_hit_i,
  input  logic [CFG_W-1:0]   prot_i,
  output logic               wr_ok_o,
  output logic               rd_ok_o,
  output logic               ext_ok_o
);

  localparam int WR_B = fld_base(FLD_WR, NUM_BLK);
  localparam int RD_B = fld_base(FLD_RD, NUM_BLK);
  localparam int CP_B = fld_base(FLD_CP, NUM_BLK);

  logic [NUM_BLK-1:0] wr_en, rd_open, cp_open;

  assign wr_en   = prot_i[WR_B +: NUM_BLK];
  assign rd_open = prot_i[RD_B +: NUM_BLK];
  assign cp_open = prot_i[CP_B +: NUM_BLK];

  // no hit means outside every block: allowed
  assign wr_ok_o  = ~|(tgt_hit_i & ~wr_en);
  assign rd_ok_o  = ~|(tgt_hit_i & ~rd_open & ~pc_hit_i);
  assign ext_ok_o = ~|(ext_hit_i & ~cp_open);

endmodule

// File: rtl/pmem_guard.sv
`timescale 1ns/1ps
module pmem_guard #(
  parameter int ADDR_W       = 24,
  parameter int DATA_W       = 8,
  parameter int BOOT_LOG2    = 11,
  parameter int USER_LOG2    = 14,
  parameter int NUM_USER_BLK = 4,
  localparam int NUM_BLK     = NUM_USER_BLK + 1,
  localparam int CFG_W       = 3 * NUM_BLK
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  tbl_addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  output logic               mem_we_o,
  output logic               mem_re_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               violation_o,
  input  logic [ADDR_W-1:0]  ext_addr_i,
  output logic               ext_grant_o,
  input  logic               cfg_wr_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  input  logic               erase_all_i,
  input  logic [NUM_BLK-1:0] erase_blk_i,
  output logic [CFG_W-1:0]   prot_o
);

  logic [NUM_BLK-1:0] tgt_hit, pc_hit, ext_hit;
  logic [CFG_W-1:0]   prot;
  logic               wr_ok, rd_ok, ext_ok;
  logic               deny;
  logic               viol_q;

  pmem_blk_decode #(
    .ADDR_W(ADDR_W), .BOOT_LOG2(BOOT_LOG2), .USER_LOG2(USER_LOG2), .NUM_BLK(NUM_BLK)
  ) i_dec_tgt (.addr_i(tbl_addr_i), .hit_o(tgt_hit));

  pmem_blk_decode #(
    .ADDR_W(ADDR_W), .BOOT_LOG2(BOOT_LOG2), .USER_LOG2(USER_LOG2), .NUM_BLK(NUM_BLK)
  ) i_dec_pc (.addr_i(pc_i), .hit_o(pc_hit));

  pmem_blk_decode #(
    .ADDR_W(ADDR_W), .BOOT_LOG2(BOOT_LOG2), .USER_LOG2(USER_LOG2), .NUM_BLK(NUM_BLK)
  ) i_dec_ext (.addr_i(ext_addr_i), .hit_o(ext_hit));

  pmem_prot_reg #(.NUM_BLK(NUM_BLK), .CFG_W(CFG_W)) i_prot (
    .clk_i       (clk_i),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .erase_all_i (erase_all_i),
    .erase_blk_i (erase_blk_i),
    .prot_o      (prot)
  );

  pmem_access_check #(.NUM_BLK(NUM_BLK), .CFG_W(CFG_W)) i_chk_acc (
    .tgt_hit_i (tgt_hit),
    .pc_hit_i  (pc_hit),
    .ext_hit_i (ext_hit),
    .prot_i    (prot),
    .wr_ok_o   (wr_ok),
    .rd_ok_o   (rd_ok),
    .ext_ok_o  (ext_ok)
  );

  assign mem_addr_o  = tbl_addr_i;
  assign mem_wdata_o = wdata_i;
  assign mem_we_o    = req_valid_i & req_write_i & wr_ok;
  assign mem_re_o    = req_valid_i & ~req_write_i;
  assign rdata_o     = rd_ok ? mem_rdata_i : '0;
  assign ext_grant_o = ext_ok;
  assign prot_o      = prot;

  assign deny = req_valid_i & (req_write_i ? ~wr_ok : ~rd_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_q <= 1'b0;
    else         viol_q <= deny;
  end

  assign violation_o = viol_q;

endmodule

// File: rtl/pmem_guard_chk.sv
`timescale 1ns/1ps
module pmem_guard_chk #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8,
  parameter int BOOT_LOG2 = 11,
  parameter int USER_LOG2 = 14,
  parameter int NUM_BLK   = 5,
  parameter int CFG_W     = 15
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  pc_i,
  input logic               req_valid_i,
  input logic               req_write_i,
  input logic [ADDR_W-1:0]  tbl_addr_i,
  input logic [DATA_W-1:0]  mem_rdata_i,
  input logic               mem_we_o,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               violation_o,
  input logic [ADDR_W-1:0]  ext_addr_i,
  input logic               ext_grant_o,
  input logic               erase_all_i,
  input logic [NUM_BLK-1:0] erase_blk_i,
  input logic [CFG_W-1:0]   prot_o
);

  localparam logic [ADDR_W:0] BOOT_SZ = (ADDR_W+1)'(1) << BOOT_LOG2;
  localparam logic [ADDR_W:0] TOP     = (ADDR_W+1)'(NUM_BLK - 1) << USER_LOG2;

  function automatic int blk_of(logic [ADDR_W-1:0] a);
    if ({1'b0, a} < BOOT_SZ) return 0;
    if ({1'b0, a} < TOP)     return 32'(a >> USER_LOG2) + 1;
    return -1;
  endfunction

  int   tgt_b, pc_b, ext_b;
  logic tgt_wr_closed, tgt_rd_closed, tgt_rd_open;

  always_comb begin
    tgt_b = blk_of(tbl_addr_i);
    pc_b  = blk_of(pc_i);
    ext_b = blk_of(ext_addr_i);
    tgt_wr_closed = 1'b0;
    tgt_rd_closed = 1'b0;
    tgt_rd_open   = 1'b0;
    for (int b = 0; b < NUM_BLK; b++) begin
      if (b == tgt_b) begin
        tgt_wr_closed = !prot_o[b];
        tgt_rd_closed = !prot_o[NUM_BLK + b];
        tgt_rd_open   =  prot_o[NUM_BLK + b];
      end
    end
  end

  assert_wr_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_write_i && tgt_wr_closed |-> !mem_we_o);

  assert_rd_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_write_i && tgt_rd_closed && (pc_b != tgt_b) |-> rdata_o == '0);

  assert_rd_open_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_write_i && tgt_rd_open |-> rdata_o == mem_rdata_i);

  assert_out_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && (tgt_b < 0) |=> !violation_o);

  assert_clear_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !erase_all_i && (erase_blk_i == '0) |=> (prot_o & ~$past(prot_o)) == '0);

  assert_erase_all_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_all_i |=> &prot_o);

  assert_ext_free_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_b < 0) |-> ext_grant_o);

  assert_viol_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    violation_o |-> $past(req_valid_i));

endmodule

bind pmem_guard pmem_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_LOG2(BOOT_LOG2),
  .USER_LOG2(USER_LOG2), .NUM_BLK(NUM_BLK), .CFG_W(CFG_W)
) i_guard_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pc_i        (pc_i),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .tbl_addr_i  (tbl_addr_i),
  .mem_rdata_i (mem_rdata_i),
  .mem_we_o    (mem_we_o),
  .rdata_o     (rdata_o),
  .violation_o (violation_o),
  .ext_addr_i  (ext_addr_i),
  .ext_grant_o (ext_grant_o),
  .erase_all_i (erase_all_i),
  .erase_blk_i (erase_blk_i),
  .prot_o      (prot_o)
);

// File: tb/test_pmem_guard.sv
`timescale 1ns/1ps
module test_pmem_guard;
  localparam int AW = 24;
  localparam int DW = 8;
  localparam int NB = 5;
  localparam int CW = 15;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic [AW-1:0] pc_i, tbl_addr_i, ext_addr_i;
  logic          req_valid_i, req_write_i;
  logic [DW-1:0] wdata_i, mem_rdata_i;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o, rdata_o;
  logic          mem_we_o, mem_re_o, violation_o, ext_grant_o;
  logic          cfg_wr_i, erase_all_i;
  logic [CW-1:0] cfg_wdata_i, prot_o;
  logic [NB-1:0] erase_blk_i;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  assign mem_rdata_i = {1'b1, tbl_addr_i[6:0]};

  pmem_guard i_pmem_guard (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bblk(logic [AW-1:0] a);
    if (a < 24'h000800) return 0;
    if (a < 24'h010000) return int'(a) / 32'h4000 + 1;
    return -1;
  endfunction

  function automatic logic [AW-1:0] pick(int i);
    case (i)
      0: return 24'h000000;  1: return 24'h0007FF;
      2: return 24'h000800;  3: return 24'h003FFF;
      4: return 24'h004000;  5: return 24'h007FFF;
      6: return 24'h008000;  7: return 24'h00BFFF;
      8: return 24'h00C000;  9: return 24'h00FFFF;
      10: return 24'h010000;
      default: return 24'hFFFFFF;
    endcase
  endfunction

  task automatic cfg_load(logic [CW-1:0] v);
    @(negedge clk_i); erase_all_i = 1'b1;
    @(negedge clk_i); erase_all_i = 1'b0; cfg_wr_i = 1'b1; cfg_wdata_i = v;
    @(posedge clk_i); #1;
    chk("R6 load", 32'(prot_o), 32'(v));
    @(negedge clk_i); cfg_wr_i = 1'b0;
  endtask

  task automatic access(logic [AW-1:0] pc, logic [AW-1:0] tgt, logic wr, logic [CW-1:0] v);
    int  b;
    bit  ok;
    string tag;
    @(negedge clk_i);
    pc_i = pc; tbl_addr_i = tgt; ext_addr_i = tgt;
    req_valid_i = 1'b1; req_write_i = wr; wdata_i = tgt[7:0];
    b = bblk(tgt);
    if (b < 0)   begin ok = 1'b1; tag = "R5"; end
    else if (wr) begin ok = v[b]; tag = "R1 R2"; end
    else begin
      ok  = v[NB+b] || (bblk(pc) == b);
      tag = v[NB+b] ? "R1 R4" : "R1 R3";
    end
    #1;
    if (wr) chk(tag, 32'(mem_we_o), 32'(ok));
    else    chk(tag, 32'(rdata_o), ok ? 32'({1'b1, tgt[6:0]}) : 32'd0);
    chk("R9", 32'(ext_grant_o), (b < 0) ? 32'd1 : 32'(v[2*NB+b]));
    @(posedge clk_i); #1;
    chk("R10 pulse", 32'(violation_o), 32'(!ok));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [CW-1:0] v;
    rst_ni = 1'b0; req_valid_i = 1'b0; req_write_i = 1'b0;
    pc_i = '0; tbl_addr_i = '0; ext_addr_i = '0; wdata_i = '0;
    cfg_wr_i = 1'b0; cfg_wdata_i = '0; erase_blk_i = '0; erase_all_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R7 reset erase", 32'(prot_o), 32'h7FFF);
    chk("R10 reset", 32'(violation_o), 32'd0);
    @(negedge clk_i); erase_all_i = 1'b0; rst_ni = 1'b1;

    // sweep protection patterns over all boundary address pairs
    for (int k = 0; k < 32; k++) begin
      v = {5'(~k), 5'(k) ^ 5'b10110, 5'(k)};
      cfg_load(v);
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          for (int w = 0; w < 2; w++)
            access(pick(i), pick(j), w[0], v);
    end

    // boot block write-locked, read-open: write from user block dropped
    v = 15'h7FFE;
    cfg_load(v);
    access(24'h003FFE, 24'h000100, 1'b1, v);
    chk("R2 boot drop", 32'(mem_we_o), 32'd0);
    @(negedge clk_i); req_valid_i = 1'b0;
    @(posedge clk_i); #1;
    chk("R10 single cycle", 32'(violation_o), 32'd0);

    // clear-only writes
    @(negedge clk_i); cfg_wr_i = 1'b1; cfg_wdata_i = 15'h7FFF;
    @(posedge clk_i); #1;
    chk("R6 set ignored", 32'(prot_o), 32'h7FFE);
    @(negedge clk_i); cfg_wdata_i = 15'h3FFF;
    @(posedge clk_i); #1;
    chk("R6 clear", 32'(prot_o), 32'h3FFE);
    @(negedge clk_i); cfg_wr_i = 1'b0;

    // reset leaves protection word untouched
    rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    #1; chk("R8 in reset", 32'(prot_o), 32'h3FFE);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R8 after reset", 32'(prot_o), 32'h3FFE);

    // block erase wins over a same-cycle clearing write
    cfg_load(15'h0000);
    @(negedge clk_i); erase_blk_i = 5'b00100; cfg_wr_i = 1'b1; cfg_wdata_i = 15'h0000;
    @(posedge clk_i); #1;
    chk("R7 block erase", 32'(prot_o), 32'h1084);
    @(negedge clk_i); erase_blk_i = '0; cfg_wr_i = 1'b0;
    @(posedge clk_i); #1;
    chk("R7 hold", 32'(prot_o), 32'h1084);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule